// File: doc/BRIEF.md
# Master Link Control-Frame Serializer

This block sits on the master side of a serial display link, between a CPU-style parallel port and a single pair of serial lines. It watches the CPU's strobe, read/write line, strobe-source select and control bus. It turns two kinds of events into short control-only frames on `ser_tx_o`. The first is a parallel-mode read request: the strobe falls while the read/write line is high. The second is a clock edge on the SPI clock in SPI mode. After a read control frame has gone out, the block turns around and listens on `ser_rx_i` for the far end's 18-bit data frame. It then drives that data onto `cpu_data_o` with a one-cycle valid pulse, so the CPU can latch it.

Every serial frame is one start bit (1), the payload least-significant bit first, and one stop bit (0), at one bit per clock. Between frames the transmit line rests at 0. The strobe and the SPI clock (control bit 5) each pass through a two-flop synchronizer before their edges are detected.

The controller has four states:
- `ST_IDLE`, which waits for an event.
- `ST_SEND_RD`, which shifts out a read control frame.
- `ST_WAIT_RX`, which waits for and collects the returning data frame.
- `ST_SEND_SPI`, which shifts out an SPI control frame.

It has these transitions:
- IDLE to SEND_RD, on a synchronized strobe fall with the read/write line high in parallel mode.
- IDLE to SEND_SPI, on a synchronized SPI clock rise with the strobe select at 0 in SPI mode.
- SEND_RD to WAIT_RX, after the stop bit.
- SEND_SPI to IDLE, after the stop bit.
- WAIT_RX to IDLE, once the data frame's stop bit has been sampled.
- SEND_RD or WAIT_RX to IDLE at once, if the read/write line drops (read abort).

Top module: `master_link_ctrl_ser`

## Requirements
- R1: While and right after reset, `ser_tx_o`, `data_valid_o` and `proto_err_o` are 0 and `cpu_data_o` is all zeros.
- R2: In parallel mode (`par_spi_n_i`=1), if the strobe is first seen low at clock edge k while `cpu_rw_i`=1, the start bit (1) is on `ser_tx_o` after edge k+2.
- R3: A control frame is 10 bits, one per clock: start 1, then payload bits 0..7, then stop 0. The payload is `cpu_ctrl_i[5:0]` in bits 0-5, `cpu_rw_i` in bit 6 and `cpu_sel_i` in bit 7. `cpu_data_i` never affects the frame. `ser_tx_o` is 0 outside a frame.
- R4: After a read control frame, the block accepts a frame on `ser_rx_i` that starts with a 1 bit, carries 18 data bits LSB first and ends with a 0 stop bit. One cycle after the stop bit is sampled, `cpu_data_o` shows the data and `data_valid_o` is high for exactly one cycle.
- R5: If `cpu_rw_i` goes low while a read control frame is being sent or while the data frame is awaited, `proto_err_o` pulses for one cycle and the block returns to idle. `ser_tx_o` drops to 0 in that same cycle, and no valid pulse follows.
- R6: If the data frame's stop bit is 1, `proto_err_o` pulses for one cycle, `data_valid_o` stays 0 and `cpu_data_o` keeps its previous value.
- R7: In SPI mode (`par_spi_n_i`=0) with `cpu_sel_i`=0, a rising edge of `cpu_ctrl_i[5]` sends a control frame with the R2 timing and the R3 format. No receive phase follows.
- R8: In SPI mode with `cpu_sel_i`=1, SPI clock edges send nothing.
- R9: A strobe fall is ignored in SPI mode, or in parallel mode when `cpu_rw_i`=0. A rise of `cpu_ctrl_i[5]` is ignored in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_spi_n_i | input | 1 | 1 = parallel mode, 0 = SPI mode |
| cpu_stb_i | input | 1 | CPU strobe, asynchronous, falling edge starts a read |
| cpu_rw_i | input | 1 | Read/write line, 1 = read |
| cpu_sel_i | input | 1 | Strobe-source select, sent as payload bit 7 |
| cpu_ctrl_i | input | 6 | Control bus; bit 5 is the SPI clock and bit 4 the SPI data in SPI mode |
| cpu_data_i | input | 18 | CPU data bus, not used by control frames |
| ser_rx_i | input | 1 | Serial data returning from the far end |
| ser_tx_o | output | 1 | Serial data towards the far end |
| cpu_data_o | output | 18 | Read data presented to the CPU |
| data_valid_o | output | 1 | One-cycle pulse when `cpu_data_o` has new read data |
| proto_err_o | output | 1 | One-cycle pulse on a read abort or a bad stop bit |

## Verification
A corrupted state register or shift counter shows up on `ser_tx_o` within one frame. The start bit appears a cycle early or late, a payload bit lands in the wrong slot, or the stop bit runs long, and the bench sees any of these by comparing every bit of every frame. A receive path that miscounts changes the cycle of the valid pulse or the assembled word, and this is visible within 20 cycles of the returning start bit. A state that fails to leave the read cycle appears as a missing valid or error pulse, and as the next read producing no frame at all.

// File: rtl/mlcs_pkg.sv
package mlcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SEND_RD  = 2'd1,
        ST_WAIT_RX  = 2'd2,
        ST_SEND_SPI = 2'd3
    } mlcs_state_e;
endpackage

// File: rtl/mlcs_sync2.sv
module mlcs_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    input  logic [W-1:0] rst_val_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= rst_val_i;
            sync_q <= rst_val_i;
            prev_q <= rst_val_i;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_o = sync_q;
    assign rise_o = sync_q & ~prev_q;
    assign fall_o = prev_q & ~sync_q;
endmodule

// File: rtl/mlcs_tx_shift.sv
module mlcs_tx_shift #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          abort_i,
    input  logic [PW-1:0] payload_i,
    output logic          tx_o,
    output logic          last_o
);
    localparam int FW = PW + 2;
    localparam int CW = $clog2(FW + 1);

    logic [FW-1:0] shreg_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            left_q  <= '0;
        end else if (abort_i) begin
            shreg_q <= '0;
            left_q  <= '0;
        end else if (load_i) begin
            shreg_q <= {1'b0, payload_i, 1'b1};
            left_q  <= CW'(FW);
        end else if (left_q != '0) begin
            shreg_q <= {1'b0, shreg_q[FW-1:1]};
            left_q  <= left_q - 1'b1;
        end
    end

    assign tx_o   = (left_q != '0) & shreg_q[0];
    assign last_o = (left_q == CW'(1));
endmodule

// File: rtl/mlcs_rx_shift.sv
module mlcs_rx_shift #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          rx_i,
    output logic          done_o,
    output logic          stop_ok_o,
    output logic [DW-1:0] data_o
);
    localparam int CW = $clog2(DW + 2);

    logic [DW-1:0] shreg_q;
    logic [CW-1:0] pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            pos_q   <= '0;
        end else if (!en_i) begin
            pos_q <= '0;
        end else if (pos_q == '0) begin
            if (rx_i) pos_q <= CW'(1);
        end else if (pos_q <= CW'(DW)) begin
            shreg_q <= {rx_i, shreg_q[DW-1:1]};
            pos_q   <= pos_q + 1'b1;
        end else begin
            pos_q <= '0;
        end
    end

    assign done_o    = en_i & (pos_q == CW'(DW + 1));
    assign stop_ok_o = ~rx_i;
    assign data_o    = shreg_q;
endmodule

// File: rtl/master_link_ctrl_ser.sv
module master_link_ctrl_ser
    import mlcs_pkg::*;
#(
    parameter int CTRL_W = 6,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_spi_n_i,
    input  logic              cpu_stb_i,
    input  logic              cpu_rw_i,
    input  logic              cpu_sel_i,
    input  logic [CTRL_W-1:0] cpu_ctrl_i,
    input  logic [DATA_W-1:0] cpu_data_i,
    input  logic              ser_rx_i,
    output logic              ser_tx_o,
    output logic [DATA_W-1:0] cpu_data_o,
    output logic              data_valid_o,
    output logic              proto_err_o
);
    localparam int PW      = CTRL_W + 2;
    localparam int SCLK_IX = CTRL_W - 1;

    mlcs_state_e state_q, state_d;

    logic [1:0] sync_in, sync_val, sync_rise, sync_fall;
    logic       stb_fall, sclk_rise;
    logic       tx_load, tx_abort, tx_last;
    logic       rx_done, rx_stop_ok;
    logic [DATA_W-1:0] rx_data;
    logic [PW-1:0]     payload;
    logic       rw_fault, rx_good, rx_bad;
    logic [DATA_W-1:0] data_q;
    logic       valid_q, err_q;
    logic       unused_data;

    assign sync_in  = {cpu_ctrl_i[SCLK_IX], cpu_stb_i};
    assign stb_fall  = sync_fall[0];
    assign sclk_rise = sync_rise[1];
    assign payload   = {cpu_sel_i, cpu_rw_i, cpu_ctrl_i};
    assign unused_data = ^{cpu_data_i, sync_val, sync_rise[0], sync_fall[1]};

    mlcs_sync2 #(.W(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_i   (sync_in),
        .rst_val_i (2'b01),
        .sync_o    (sync_val),
        .rise_o    (sync_rise),
        .fall_o    (sync_fall)
    );

    mlcs_tx_shift #(.PW(PW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tx_load),
        .abort_i   (tx_abort),
        .payload_i (payload),
        .tx_o      (ser_tx_o),
        .last_o    (tx_last)
    );

    mlcs_rx_shift #(.DW(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (state_q == ST_WAIT_RX),
        .rx_i      (ser_rx_i),
        .done_o    (rx_done),
        .stop_ok_o (rx_stop_ok),
        .data_o    (rx_data)
    );

    assign rw_fault = ((state_q == ST_SEND_RD) || (state_q == ST_WAIT_RX)) && !cpu_rw_i;
    assign rx_good  = (state_q == ST_WAIT_RX) && cpu_rw_i && rx_done && rx_stop_ok;
    assign rx_bad   = (state_q == ST_WAIT_RX) && cpu_rw_i && rx_done && !rx_stop_ok;

    // next-state logic
    always_comb begin
        state_d  = state_q;
        tx_load  = 1'b0;
        tx_abort = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!par_spi_n_i) begin
                    if (sclk_rise && !cpu_sel_i) begin
                        state_d = ST_SEND_SPI;
                        tx_load = 1'b1;
                    end
                end else if (stb_fall && cpu_rw_i) begin
                    state_d = ST_SEND_RD;
                    tx_load = 1'b1;
                end
            end
            ST_SEND_RD: begin
                if (!cpu_rw_i) begin
                    state_d  = ST_IDLE;
                    tx_abort = 1'b1;
                end else if (tx_last) begin
                    state_d = ST_WAIT_RX;
                end
            end
            ST_WAIT_RX: begin
                if (!cpu_rw_i || rx_done) state_d = ST_IDLE;
            end
            ST_SEND_SPI: begin
                if (tx_last) state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= rx_good;
            err_q   <= rw_fault || rx_bad;
            if (rx_good) data_q <= rx_data;
        end
    end

    assign cpu_data_o   = data_q;
    assign data_valid_o = valid_q;
    assign proto_err_o  = err_q;
endmodule

// File: rtl/master_link_ctrl_ser_chk.sv
module master_link_ctrl_ser_chk
    import mlcs_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input mlcs_state_e       state_q,
    input logic              ser_tx_o,
    input logic [DATA_W-1:0] cpu_data_o,
    input logic              data_valid_o,
    input logic              proto_err_o
);
    AST_TX_QUIET_OUTSIDE_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_WAIT_RX) |-> !ser_tx_o); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |=> !data_valid_o); // R4
    AST_VALID_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> $past(state_q) == ST_WAIT_RX); // R4
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> !proto_err_o); // R5
    AST_ERR_EXCLUDES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> !data_valid_o); // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid_o |-> $stable(cpu_data_o)); // R6
    AST_SPI_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND_SPI) |=> (state_q != ST_WAIT_RX)); // R7
endmodule

bind master_link_ctrl_ser master_link_ctrl_ser_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .ser_tx_o     (ser_tx_o),
    .cpu_data_o   (cpu_data_o),
    .data_valid_o (data_valid_o),
    .proto_err_o  (proto_err_o)
);

// File: tb/master_link_ctrl_ser_tb.sv
module master_link_ctrl_ser_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        par_spi_n = 1'b1;
    logic        stb = 1'b1;
    logic        rw = 1'b1;
    logic        sel = 1'b0;
    logic [5:0]  ctrl = '0;
    logic [17:0] dbus = '0;
    logic        rx = 1'b0;
    logic        tx;
    logic [17:0] dout;
    logic        valid, err;

    int total = 0;
    int fails = 0;
    bit done = 0;
    logic [17:0] last_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    master_link_ctrl_ser u_dut (
        .clk(clk), .rst_n(rst_n), .par_spi_n_i(par_spi_n), .cpu_stb_i(stb),
        .cpu_rw_i(rw), .cpu_sel_i(sel), .cpu_ctrl_i(ctrl), .cpu_data_i(dbus),
        .ser_rx_i(rx), .ser_tx_o(tx), .cpu_data_o(dout),
        .data_valid_o(valid), .proto_err_o(err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts a read (R2) and samples the 10 frame bits, first after edge k+2.
    task automatic send_read(input logic [5:0] c, input logic s, output logic [9:0] got);
        @(negedge clk); rw = 1'b1; ctrl = c; sel = s; dbus = ~{c, c, c};
        @(negedge clk); stb = 1'b0;
        repeat (2) @(negedge clk);
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            got[j] = tx;
        end
    endtask

    task automatic full_read(input logic [5:0] c, input logic s, input logic [17:0] d, input bit bad_stop);
        logic [9:0] got;
        send_read(c, s, got);
        chk(got == {1'b0, s, 1'b1, c, 1'b1}, "R2/R3 read frame", 32'(got), 32'({1'b0, s, 1'b1, c, 1'b1}));
        @(negedge clk); stb = 1'b1; rx = 1'b1;
        for (int j = 0; j < 18; j++) begin
            @(negedge clk); rx = d[j];
        end
        @(negedge clk); rx = bad_stop;
        @(negedge clk); rx = 1'b0;
        if (!bad_stop) begin
            chk(valid && !err && dout == d, "R4 data presented", 32'({valid, err, dout}), 32'({2'b10, d}));
            last_data = d;
        end else begin
            chk(err && !valid && dout == last_data, "R6 bad stop", 32'({valid, err, dout}), 32'({2'b01, last_data}));
        end
        @(negedge clk);
        chk(!valid && !err, "R4/R5 pulse one cycle", 32'({valid, err}), 32'd0);
    endtask

    task automatic expect_silent(input int n, input string req);
        int hits = 0;
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            if (tx || valid || err) hits++;
        end
        chk(hits == 0, req, 32'(hits), 32'd0);
    endtask

    task automatic spi_xfer(input logic [4:0] c, input logic s);
        logic [9:0] got;
        logic [9:0] exp;
        @(negedge clk); ctrl = {1'b0, c}; sel = s; rw = c[0];
        @(negedge clk); ctrl[5] = 1'b1;
        repeat (2) @(negedge clk);
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            got[j] = tx;
        end
        exp = s ? 10'd0 : {1'b0, s, c[0], 1'b1, c, 1'b1};
        chk(got == exp, s ? "R8 spi sel=1 silent" : "R7 spi frame", 32'(got), 32'(exp));
        @(negedge clk); ctrl[5] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [9:0] g;
        repeat (3) @(negedge clk);
        chk(!tx && !valid && !err && dout == '0, "R1 in reset", 32'({tx, valid, err, dout}), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!tx && !valid && !err && dout == '0, "R1 after reset", 32'({tx, valid, err, dout}), 32'd0);
        expect_silent(5, "R1 idle quiet");

        // R2 R3 R4: sweep all control and select values
        for (int i = 0; i < 128; i++) begin
            logic [17:0] d;
            d = (i == 1) ? 18'h3FFFF : 18'(i * 92821 + 5);
            full_read(6'(i), i[6], d, 1'b0);
            expect_silent(3, "R3 line low between frames");
        end

        // R6: bad stop keeps data
        full_read(6'h2A, 1'b1, 18'h12345, 1'b1);
        expect_silent(4, "R6 back to idle");

        // R5: read/write drops mid-frame
        @(negedge clk); rw = 1'b1; ctrl = 6'h15; sel = 1'b0;
        @(negedge clk); stb = 1'b0;
        repeat (5) @(negedge clk);
        rw = 1'b0;
        @(negedge clk);
        chk(err && !tx, "R5 abort in frame", 32'({err, tx}), 32'h2);
        @(negedge clk); stb = 1'b1;
        chk(!err, "R5 err one cycle", 32'(err), 32'd0);
        @(negedge clk); rw = 1'b1;
        expect_silent(30, "R5 no valid after abort");

        // R5: read/write drops while waiting for data
        send_read(6'h0C, 1'b0, g);
        @(negedge clk); stb = 1'b1; rw = 1'b0;
        @(negedge clk);
        chk(err && !valid, "R5 abort in wait", 32'({err, valid}), 32'h2);
        @(negedge clk); rw = 1'b1;
        expect_silent(10, "R5 idle after abort");
        full_read(6'h07, 1'b0, 18'h2AAAA, 1'b0);

        // R9: ignored events
        @(negedge clk); rw = 1'b0; stb = 1'b0;
        expect_silent(12, "R9 write strobe ignored");
        @(negedge clk); stb = 1'b1; rw = 1'b1; ctrl = 6'h00;
        repeat (4) @(negedge clk); ctrl[5] = 1'b1;
        expect_silent(12, "R9 spi clock ignored in parallel mode");
        @(negedge clk); ctrl = 6'h00; par_spi_n = 1'b0;
        repeat (4) @(negedge clk); stb = 1'b0;
        expect_silent(12, "R9 strobe ignored in spi mode");
        @(negedge clk); stb = 1'b1;
        repeat (4) @(negedge clk);

        // R7 R8: SPI sweep
        for (int i = 0; i < 64; i++) begin
            spi_xfer(5'(i), i[5]);
            expect_silent(i[5] ? 3 : 25, "R7 no receive after spi frame");
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule